// File: doc/BRIEF.md
# Flash Block Protection Manager

This block holds the write protection of every erase block in a boot-block NOR flash model. Each block carries two stored bits: a lock bit and a lock-down bit. Decoded lock, unlock and lock-down requests arrive with a word address. An address decoder turns that address into a block index. The decoder handles the boot-block layout: one region the size of a main block is split into smaller parameter blocks, and that region sits at the bottom or the top of the address space, selected by a parameter.

The program/erase path presents an address. In the same cycle it is told whether the target block may be written. A refused attempt raises a one-cycle protection-error strobe, which the status logic uses to set its block-protection bit. A third address port returns a two-bit lock signature for reads.

Protection depends on the write-protect pin as well as on the two stored bits. While the pin is low, a locked-down block cannot be unlocked. While the pin is high, a locked-down block behaves like an ordinary locked block. When the pin returns low, the lock-down protection applies again. The lock-down bit itself is cleared only by reset.

Top module: `flash_lock_mgr`

## Requirements
- R1: After reset every block reads signature 2'b01 (lock-down bit 0, protected 1), and every program/erase attempt is refused.
- R2: A request with `req_op` = 1 (lock) makes the addressed block protected from the next cycle on.
- R3: A request with `req_op` = 2 (unlock) on a block whose lock-down bit is clear makes it unprotected from the next cycle on, so a program/erase attempt there is granted.
- R4: A request with `req_op` = 3 (lock-down) sets both the lock bit and the lock-down bit (signature 2'b11), whether the block was locked or unlocked before. The lock-down bit stays set until reset.
- R5: While `wp_pin` is 0, an unlock request to a block whose lock-down bit is set is ignored. The signature stays 2'b11 and program/erase attempts stay refused.
- R6: While `wp_pin` is 1, a locked-down block can be unlocked (signature 2'b10, attempts granted). When `wp_pin` returns to 0, the block is protected again (signature 2'b11) without any new request.
- R7: `pe_grant` equals `pe_vld` and not-protected in the same cycle. A refused attempt drives `prot_err` high for exactly the following cycle, and a granted attempt never drives it.
- R8: When a request and a program/erase attempt target the same block in the same cycle, the attempt is judged on the protection held before that request.
- R9: With the bottom-boot default, addresses below 0x8000 map to eight 4 Kword parameter blocks (address bits 14:12 select the block). Each 32 Kword region above maps to one main block.
- R10: A request changes only the addressed block; all other blocks keep their signatures.
- R11: `sig_data` bit 0 is the effective protection of the block at `sig_addr` and bit 1 is its lock-down bit. Both are combinational from the stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; locks every block |
| wp_pin | input | 1 | Write-protect pin; 0 enforces lock-down |
| req_vld | input | 1 | Protection request valid |
| req_op | input | 2 | 1 lock, 2 unlock, 3 lock-down, 0 none |
| req_addr | input | ADDR_W | Word address of the request's block |
| pe_vld | input | 1 | Program/erase attempt valid |
| pe_addr | input | ADDR_W | Word address of the attempt |
| pe_grant | output | 1 | Attempt allowed this cycle |
| prot_err | output | 1 | One-cycle strobe after a refused attempt |
| sig_addr | input | ADDR_W | Word address for the signature read |
| sig_data | output | 2 | {lock-down bit, effective protection} |

## Verification
A protection request and a program/erase attempt can fall in the same cycle on the same block. The bench provokes this by driving both at one falling edge. One case locks an unlocked block; the other unlocks a locked block. The grant in that cycle must reflect the old state, and the grant or error strobe in the following cycle must reflect the new one. The interplay of the write-protect pin with stored lock-down bits is driven by toggling the pin around unlock requests, with no request in between.

// File: rtl/flk_pkg.sv
package flk_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_LOCKDN = 2'd3
    } lock_op_e;
endpackage

// File: rtl/flk_blk_decode.sv
module flk_blk_decode #(
    parameter int ADDR_W   = 22,
    parameter int MAIN_W   = 15,
    parameter int PARAM_W  = 12,
    parameter bit TOP_BOOT = 1'b0,
    parameter int IDX_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int REG_W   = ADDR_W - MAIN_W;
    localparam int SUB_W   = MAIN_W - PARAM_W;
    localparam int REGIONS = 1 << REG_W;
    localparam int NPARAM  = 1 << SUB_W;

    logic [REG_W-1:0] region;
    logic [SUB_W-1:0] sub;

    assign region = addr[ADDR_W-1:MAIN_W];
    assign sub    = addr[MAIN_W-1:PARAM_W];

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                if (int'(region) == REGIONS - 1)
                    idx = IDX_W'(REGIONS - 1 + int'(sub));
                else
                    idx = IDX_W'(int'(region));
            end
        end else begin : g_bot
            always_comb begin
                if (region == '0)
                    idx = IDX_W'(int'(sub));
                else
                    idx = IDX_W'(NPARAM - 1 + int'(region));
            end
        end
    endgenerate
endmodule

// File: rtl/flk_state_array.sv
module flk_state_array
    import flk_pkg::*;
#(
    parameter int NBLK  = 135,
    parameter int IDX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wp_pin,
    input  logic            op_vld,
    input  lock_op_e        op,
    input  logic [IDX_W-1:0] idx,
    output logic [NBLK-1:0] prot_o,
    output logic [NBLK-1:0] ld_o
);
    typedef struct packed {
        logic [NBLK-1:0] lk;
        logic [NBLK-1:0] ld;
    } st_t;

    st_t st_d, st_q;
    logic idx_ok;

    assign idx_ok = int'(idx) < NBLK;

    always_comb begin
        st_d = st_q;
        if (op_vld && idx_ok) begin
            case (op)
                OP_LOCK:   st_d.lk[idx] = 1'b1;
                OP_UNLOCK: if (!(st_q.ld[idx] && !wp_pin)) st_d.lk[idx] = 1'b0;
                OP_LOCKDN: begin
                    st_d.lk[idx] = 1'b1;
                    st_d.ld[idx] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lk <= '1;
            st_q.ld <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign prot_o = st_q.lk | (st_q.ld & {NBLK{~wp_pin}});
    assign ld_o   = st_q.ld;

    // R1: first cycle out of reset shows all blocks locked, none locked down
    p_reset_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ((&st_q.lk) && (st_q.ld == '0)));

    // R4: a lock-down bit is never cleared while out of reset
    p_ld_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(st_q.ld) & ~st_q.ld) == '0));

    p_lockdn_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op == OP_LOCKDN && idx_ok)
        |=> (st_q.lk[$past(idx)] && st_q.ld[$past(idx)]));

    // R5: unlock of a locked-down block with the pin low leaves the lock bit
    p_unlock_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op == OP_UNLOCK && idx_ok && st_q.ld[idx] && !wp_pin)
        |=> (st_q.lk[$past(idx)] == $past(st_q.lk[idx])));
endmodule

// File: rtl/flash_lock_mgr.sv
module flash_lock_mgr
    import flk_pkg::*;
#(
    parameter int ADDR_W   = 22,
    parameter int MAIN_W   = 15,
    parameter int PARAM_W  = 12,
    parameter bit TOP_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_pin,
    input  logic              req_vld,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              pe_vld,
    input  logic [ADDR_W-1:0] pe_addr,
    output logic              pe_grant,
    output logic              prot_err,
    input  logic [ADDR_W-1:0] sig_addr,
    output logic [1:0]        sig_data
);
    localparam int NBLK  = (1 << (ADDR_W - MAIN_W)) - 1 + (1 << (MAIN_W - PARAM_W));
    localparam int IDX_W = $clog2(NBLK);

    logic [IDX_W-1:0] req_idx, pe_idx, sig_idx;
    logic [NBLK-1:0]  prot_v, ld_v;
    logic             pe_prot;

    typedef struct packed {
        logic perr;
    } top_st_t;
    top_st_t st_d, st_q;

    flk_blk_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
        u_dec_req (.addr(req_addr), .idx(req_idx));

    flk_blk_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
        u_dec_pe (.addr(pe_addr), .idx(pe_idx));

    flk_blk_decode #(.ADDR_W(ADDR_W), .MAIN_W(MAIN_W), .PARAM_W(PARAM_W),
                     .TOP_BOOT(TOP_BOOT), .IDX_W(IDX_W))
        u_dec_sig (.addr(sig_addr), .idx(sig_idx));

    flk_state_array #(.NBLK(NBLK), .IDX_W(IDX_W)) u_state (
        .clk    (clk),
        .rst_n  (rst_n),
        .wp_pin (wp_pin),
        .op_vld (req_vld),
        .op     (lock_op_e'(req_op)),
        .idx    (req_idx),
        .prot_o (prot_v),
        .ld_o   (ld_v)
    );

    // out-of-range indices are treated as protected
    assign pe_prot  = (int'(pe_idx) < NBLK) ? prot_v[pe_idx] : 1'b1;
    assign pe_grant = pe_vld && !pe_prot;

    always_comb begin
        st_d      = st_q;
        st_d.perr = pe_vld && pe_prot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prot_err = st_q.perr;
    assign sig_data = (int'(sig_idx) < NBLK) ? {ld_v[sig_idx], prot_v[sig_idx]} : 2'b01;

    // R7: an error strobe only follows a refused attempt
    p_err_after_refusal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ($past(pe_vld) && !$past(pe_grant)));

    // R5: a locked-down block is never granted while the pin is low
    p_ld_enforced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_vld && !wp_pin && int'(pe_idx) < NBLK && ld_v[pe_idx]) |-> !pe_grant);
endmodule

// File: tb/flash_lock_mgr_tb_top.sv
module flash_lock_mgr_tb_top;
    localparam int AW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wp_pin = 1'b0;
    logic          req_vld = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic          pe_vld = 1'b0;
    logic [AW-1:0] pe_addr = '0;
    logic          pe_grant, prot_err;
    logic [AW-1:0] sig_addr = '0;
    logic [1:0]    sig_data;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    flash_lock_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .wp_pin(wp_pin),
        .req_vld(req_vld), .req_op(req_op), .req_addr(req_addr),
        .pe_vld(pe_vld), .pe_addr(pe_addr), .pe_grant(pe_grant),
        .prot_err(prot_err), .sig_addr(sig_addr), .sig_data(sig_data)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input int op, input logic [AW-1:0] a);
        @(negedge clk);
        req_vld = 1'b1; req_op = 2'(op); req_addr = a;
        @(negedge clk);
        req_vld = 1'b0; req_op = 2'd0;
    endtask

    task automatic rd_sig(input logic [AW-1:0] a, input int exp, input string tag);
        sig_addr = a;
        #1;
        chk(tag, int'(sig_data), exp);
    endtask

    task automatic pe_try(input logic [AW-1:0] a, input int exp_grant, input string tag);
        @(negedge clk);
        pe_vld = 1'b1; pe_addr = a;
        #1 chk({tag, " grant"}, int'(pe_grant), exp_grant);
        @(negedge clk);
        pe_vld = 1'b0;
        #1 chk({tag, " R7 strobe"}, int'(prot_err), 1 - exp_grant);
        @(negedge clk);
        #1 chk({tag, " R7 strobe end"}, int'(prot_err), 0);
    endtask

    task automatic t_reset;
        rd_sig(22'h000000, 1, "R1 param0");
        rd_sig(22'h3F8000, 1, "R1 last main");
        rd_sig(22'h010000, 1, "R1 main");
        pe_try(22'h010000, 0, "R1 pe");
    endtask

    task automatic t_lock_unlock;
        do_req(2, 22'h010000);
        rd_sig(22'h010000, 0, "R3 unlocked");
        rd_sig(22'h018000, 1, "R10 neighbour");
        rd_sig(22'h008000, 1, "R10 other");
        pe_try(22'h017FFF, 1, "R3 pe");
        do_req(1, 22'h010000);
        rd_sig(22'h010000, 1, "R2 relocked");
        pe_try(22'h010000, 0, "R2 pe");
    endtask

    task automatic t_param;
        do_req(2, 22'h001000);
        rd_sig(22'h001000, 0, "R9 param1");
        rd_sig(22'h001FFF, 0, "R9 param1 end");
        rd_sig(22'h000FFF, 1, "R9 param0");
        rd_sig(22'h002000, 1, "R9 param2");
        rd_sig(22'h008000, 1, "R9 first main");
        do_req(2, 22'h007000);
        rd_sig(22'h007000, 0, "R9 param7");
        rd_sig(22'h006FFF, 1, "R9 param6");
    endtask

    task automatic t_lockdown;
        wp_pin = 1'b0;
        do_req(2, 22'h020000);
        do_req(3, 22'h020000);
        rd_sig(22'h020000, 3, "R4 from unlocked");
        do_req(3, 22'h028000);
        rd_sig(22'h028000, 3, "R4 from locked");
        rd_sig(22'h030000, 1, "R10 beside lockdown");
        do_req(2, 22'h020000);
        rd_sig(22'h020000, 3, "R5 unlock ignored");
        pe_try(22'h020000, 0, "R5 pe");
        @(negedge clk); wp_pin = 1'b1;
        do_req(2, 22'h020000);
        rd_sig(22'h020000, 2, "R6 unlocked under pin high");
        pe_try(22'h020000, 1, "R6 pe granted");
        rd_sig(22'h028000, 3, "R6 other ld block");
        @(negedge clk); wp_pin = 1'b0;
        rd_sig(22'h020000, 3, "R6 pin low reapplies");
        pe_try(22'h020000, 0, "R6 pe refused");
        do_req(1, 22'h020000);
        rd_sig(22'h020000, 3, "R4 ld bit kept");
    endtask

    task automatic t_same_cycle;
        do_req(2, 22'h030000);
        @(negedge clk);
        req_vld = 1'b1; req_op = 2'd1; req_addr = 22'h030000;
        pe_vld = 1'b1; pe_addr = 22'h030000;
        #1 chk("R8 lock+pe old state", int'(pe_grant), 1);
        @(negedge clk);
        req_vld = 1'b0; req_op = 2'd0;
        #1 chk("R8 no strobe", int'(prot_err), 0);
        chk("R8 new state refused", int'(pe_grant), 0);
        @(negedge clk);
        pe_vld = 1'b0;
        #1 chk("R8 R7 strobe", int'(prot_err), 1);
        @(negedge clk);
        req_vld = 1'b1; req_op = 2'd2; req_addr = 22'h030000;
        pe_vld = 1'b1; pe_addr = 22'h030000;
        #1 chk("R8 unlock+pe old state", int'(pe_grant), 0);
        @(negedge clk);
        req_vld = 1'b0; req_op = 2'd0;
        #1 chk("R8 strobe from old", int'(prot_err), 1);
        chk("R8 new state granted", int'(pe_grant), 1);
        @(negedge clk);
        pe_vld = 1'b0;
        #1 chk("R8 no strobe after grant", int'(prot_err), 0);
        rd_sig(22'h030000, 0, "R11 sig after unlock");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_lock_unlock();
        t_param();
        t_lockdown();
        t_same_cycle();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule